// File: doc/BRIEF.md
# Fully Associative Translation Buffer with LRU Replacement

This block caches page-table mappings from virtual page numbers to physical page numbers. A lookup presents a virtual page number, the in-page offset and an access kind (read, write or execute). Every valid entry is compared against the lookup in parallel. One clock later the block reports a hit or a miss, the physical page number, the physical address, a protection-fault flag and the entry's modified flag. The physical address is the physical page number with the untouched offset appended.

After a miss, an external page-table walker installs the mapping through the refill port. Refill takes the lowest-numbered empty slot. When every slot is full, it replaces the entry that was least recently touched. A per-entry age counter records that order, and both hits and refills update it. A successful write hit marks the entry as modified, so that replacement software knows the page must be written back. A single flush pulse empties the whole buffer.

Top module: `tlb_fa_lru`

## Requirements
- R1: After reset, and after a flush, every entry is empty: `rsp_valid` is low straight after reset, and every lookup reports a miss until a refill installs a mapping.
- R2: A lookup accepted in cycle N (lk_valid high, rf_valid and flush low) produces `rsp_valid` in cycle N+1. On a hit, `rsp_ppn` is the stored physical page number and `rsp_paddr` is `{rsp_ppn, lk_offset}`.
- R3: A lookup that matches no valid entry reports `rsp_miss` high, `rsp_hit` low, `rsp_ppn` zero, `rsp_fault` low and `rsp_dirty` low, and `rsp_paddr` is `{0, lk_offset}`.
- R4: Rights are stored as three bits (bit 0 read, bit 1 write, bit 2 execute). The access kind is coded 0 read, 1 write, 2 execute, and 3 is reserved. A hit whose kind has its right bit clear raises `rsp_fault`, and the reserved kind always faults. A miss never faults.
- R5: A write hit with the write right sets the entry's modified flag. Read hits, execute hits and faulting writes leave it unchanged. `rsp_dirty` reports the flag as it stands after the access, and a refill clears it.
- R6: The buffer holds ENTRIES (64) distinct mappings at once. While any entry is empty, a refill never displaces a valid mapping.
- R7: With every entry valid, a refill of a new page replaces the entry whose last hit or refill is oldest. Lookups that miss do not change this order.
- R8: A refill whose virtual page is already present overwrites that entry in place and displaces nothing else.
- R9: When a refill and a lookup arrive in the same cycle, the refill is performed and `rsp_valid` stays low in the next cycle.
- R10: A flush wins over a refill or lookup in the same cycle: all entries become empty, the refill is dropped and no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W (20) | Virtual page number to translate |
| lk_offset | input | OFF_W (12) | In-page offset, passed to the physical address |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W (20) | Virtual page number being installed |
| rf_ppn | input | PPN_W (20) | Physical page number being installed |
| rf_perm | input | 3 | Rights: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Empty the whole buffer |
| rsp_valid | output | 1 | Response for the lookup of the previous cycle |
| rsp_hit | output | 1 | Lookup matched a valid entry |
| rsp_miss | output | 1 | Lookup matched no entry |
| rsp_fault | output | 1 | Access kind not permitted by the hit entry |
| rsp_ppn | output | PPN_W (20) | Physical page number (zero on miss) |
| rsp_paddr | output | PPN_W+OFF_W (32) | Physical address |
| rsp_dirty | output | 1 | Modified flag of the hit entry after this access |

## Verification
Each lookup result is registered once, so it appears on the clock edge after the request. A refill or flush changes the stored state on its own edge, so a lookup in the following cycle already sees it. The bench drives each request on a falling edge and removes it at the next falling edge. It reads the response at that second falling edge, half a period after the edge that registered it. Replacement order is probed only through later lookups, and each of those lookups is itself a timed request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_WR = 1;
  localparam int PERM_X = 2;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N     = 64,
  parameter int KEY_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0]              vld,
  input  logic [N-1:0][KEY_W-1:0]   keys,
  input  logic [KEY_W-1:0]          probe,
  output logic                      any,
  output logic [IDX_W-1:0]          idx
);

  logic [N-1:0] match;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign match[g] = vld[g] && (keys[g] == probe);
    end
  endgenerate

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) idx = idx | IDX_W'(i);
    end
  end

  // R8
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] oldest_idx
);

  logic [N-1:0][IDX_W-1:0] age_q, age_d;
  logic [N-1:0]            oldest_vec;
  logic [IDX_W-1:0]        cur_age;
  logic                    age_en;

  assign cur_age = age_q[touch_idx];
  assign age_en  = flush || touch;

  always_comb begin
    age_d = age_q;
    if (flush) begin
      for (int i = 0; i < N; i++) age_d[i] = IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx)   age_d[i] = '0;
        else if (age_q[i] < cur_age)  age_d[i] = age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (age_en) begin
      age_q <= age_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_old
      assign oldest_vec[g] = (age_q[g] == IDX_W'(N - 1));
    end
  endgenerate

  always_comb begin
    oldest_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (oldest_vec[i]) oldest_idx = oldest_idx | IDX_W'(i);
    end
  end

  // R7
  one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(oldest_vec));

  // R7
  touch_youngest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && !flush) |=> (age_q[$past(touch_idx)] == '0));

endmodule

// File: rtl/tlb_alloc.sv
module tlb_alloc #(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vld,
  input  logic [IDX_W-1:0] oldest_idx,
  output logic             full,
  output logic [IDX_W-1:0] slot_idx
);

  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld[i]) free_idx = IDX_W'(i);
    end
  end

  assign full     = &vld;
  assign slot_idx = full ? oldest_idx : free_idx;

endmodule

// File: rtl/tlb_fa_lru.sv
module tlb_fa_lru #(
  parameter int ENTRIES = 64,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [OFF_W-1:0]  lk_offset,
  input  logic [1:0]        lk_kind,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [2:0]        rf_perm,
  input  logic              flush,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_fault,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_dirty
);

  import tlb_pkg::*;

  // entry storage
  logic [ENTRIES-1:0]                  vld_q, vld_d;
  logic [ENTRIES-1:0]                  dirty_q, dirty_d;
  logic [ENTRIES-1:0][VPN_W-1:0]       vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]       ppn_q;
  logic [ENTRIES-1:0][PERM_W-1:0]      perm_q;

  // control
  logic             do_fill, do_look;
  logic             lk_any, rf_any, full;
  logic [IDX_W-1:0] lk_idx, rf_idx, slot_idx, fill_idx, oldest_idx;
  logic             touch;
  logic [IDX_W-1:0] touch_idx;
  logic             allowed, is_write;
  logic [PERM_W-1:0] hit_perm;
  acc_kind_e        kind;

  // response next state
  logic              rsp_en;
  logic              hit_d, miss_d, fault_d, rdirty_d;
  logic [PPN_W-1:0]  ppn_d;
  logic [PA_W-1:0]   paddr_d;

  assign do_fill = rf_valid && !flush;
  assign do_look = lk_valid && !rf_valid && !flush;

  tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_lk (
    .clk(clk), .rst_n(rst_n), .vld(vld_q), .keys(vpn_q),
    .probe(lk_vpn), .any(lk_any), .idx(lk_idx)
  );

  tlb_cam #(.N(ENTRIES), .KEY_W(VPN_W)) u_cam_rf (
    .clk(clk), .rst_n(rst_n), .vld(vld_q), .keys(vpn_q),
    .probe(rf_vpn), .any(rf_any), .idx(rf_idx)
  );

  tlb_alloc #(.N(ENTRIES)) u_alloc (
    .vld(vld_q), .oldest_idx(oldest_idx), .full(full), .slot_idx(slot_idx)
  );

  assign fill_idx  = rf_any ? rf_idx : slot_idx;
  assign touch     = do_fill || (do_look && lk_any);
  assign touch_idx = do_fill ? fill_idx : lk_idx;

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk(clk), .rst_n(rst_n), .flush(flush), .touch(touch),
    .touch_idx(touch_idx), .oldest_idx(oldest_idx)
  );

  // rights check
  assign kind     = acc_kind_e'(lk_kind);
  assign hit_perm = perm_q[lk_idx];
  assign is_write = (kind == ACC_WRITE);

  always_comb begin
    case (kind)
      ACC_READ:  allowed = hit_perm[PERM_R];
      ACC_WRITE: allowed = hit_perm[PERM_WR];
      ACC_EXEC:  allowed = hit_perm[PERM_X];
      default:   allowed = 1'b0;
    endcase
  end

  // entry state next-state
  always_comb begin
    vld_d   = vld_q;
    dirty_d = dirty_q;
    if (flush) begin
      vld_d = '0;
    end else if (do_fill) begin
      vld_d[fill_idx]   = 1'b1;
      dirty_d[fill_idx] = 1'b0;
    end else if (do_look && lk_any && allowed && is_write) begin
      dirty_d[lk_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dirty_q <= '0;
    end else begin
      vld_q   <= vld_d;
      dirty_q <= dirty_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_ent
      logic wr_en;
      assign wr_en = do_fill && (fill_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (wr_en) begin
          vpn_q[g]  <= rf_vpn;
          ppn_q[g]  <= rf_ppn;
          perm_q[g] <= rf_perm;
        end
      end
    end
  endgenerate

  // response next-state
  always_comb begin
    hit_d    = do_look && lk_any;
    miss_d   = do_look && !lk_any;
    fault_d  = hit_d && !allowed;
    ppn_d    = hit_d ? ppn_q[lk_idx] : '0;
    paddr_d  = do_look ? {ppn_d, lk_offset} : '0;
    rdirty_d = hit_d && (dirty_q[lk_idx] || (allowed && is_write));
  end

  assign rsp_en = do_look || rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_ppn   <= '0;
      rsp_paddr <= '0;
      rsp_dirty <= 1'b0;
    end else if (rsp_en) begin
      rsp_valid <= do_look;
      rsp_hit   <= hit_d;
      rsp_miss  <= miss_d;
      rsp_fault <= fault_d;
      rsp_ppn   <= ppn_d;
      rsp_paddr <= paddr_d;
      rsp_dirty <= rdirty_d;
    end
  end

  // R2
  look_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !rf_valid && !flush) |=> (rsp_valid && (rsp_hit != rsp_miss)));

  // R9
  fill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && rf_valid) |=> !rsp_valid);

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0 && !rsp_valid));

  // R3
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_ppn == '0 && !rsp_fault && !rsp_dirty));

  // R4
  fault_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit);

  // R5
  write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !rsp_fault && $past(lk_kind) == 2'd1) |-> rsp_dirty);

  // R6
  no_early_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_fill && !rf_any && !full) |-> !vld_q[fill_idx]);

endmodule

// File: tb/tb_tlb_fa_lru.sv
`timescale 1ns/1ps
module tb_tlb_fa_lru;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [19:0] lk_vpn;
  logic [11:0] lk_offset;
  logic [1:0]  lk_kind;
  logic        rf_valid;
  logic [19:0] rf_vpn;
  logic [19:0] rf_ppn;
  logic [2:0]  rf_perm;
  logic        flush;
  logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
  logic [19:0] rsp_ppn;
  logic [31:0] rsp_paddr;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tlb_fa_lru dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_offset(lk_offset), .lk_kind(lk_kind),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_perm(rf_perm),
    .flush(flush),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn), .rsp_paddr(rsp_paddr),
    .rsp_dirty(rsp_dirty)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [19:0] vpn;
    logic [11:0] off;
    logic        hit;
    logic        fault;
    logic [19:0] ppn;
    logic        dirty;
  } vec_t;

  // Entries set up before the table: 0x00010 rw, 0x00020 r, 0x00030 rx, 0xFFFFF rwx
  localparam vec_t VECS [12] = '{
    '{2'd0, 20'h00010, 12'h123, 1'b1, 1'b0, 20'h0A000, 1'b0},
    '{2'd1, 20'h00010, 12'h456, 1'b1, 1'b0, 20'h0A000, 1'b1},
    '{2'd0, 20'h00010, 12'h000, 1'b1, 1'b0, 20'h0A000, 1'b1},
    '{2'd1, 20'h00020, 12'hFFF, 1'b1, 1'b1, 20'h0B000, 1'b0},
    '{2'd0, 20'h00020, 12'h011, 1'b1, 1'b0, 20'h0B000, 1'b0},
    '{2'd2, 20'h00030, 12'h7A0, 1'b1, 1'b0, 20'h0C000, 1'b0},
    '{2'd1, 20'h00030, 12'h001, 1'b1, 1'b1, 20'h0C000, 1'b0},
    '{2'd2, 20'h00010, 12'h002, 1'b1, 1'b1, 20'h0A000, 1'b1},
    '{2'd0, 20'h00040, 12'h3C3, 1'b0, 1'b0, 20'h00000, 1'b0},
    '{2'd2, 20'hFFFFF, 12'hABC, 1'b1, 1'b0, 20'hFFFFF, 1'b0},
    '{2'd1, 20'hFFFFF, 12'hFFF, 1'b1, 1'b0, 20'hFFFFF, 1'b1},
    '{2'd3, 20'hFFFFF, 12'h800, 1'b1, 1'b1, 20'hFFFFF, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_refill(input logic [19:0] v, input logic [19:0] p,
                           input logic [2:0] perm);
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = v; rf_ppn = p; rf_perm = perm;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [1:0] k, input logic [19:0] v,
                           input logic [11:0] off);
    @(negedge clk);
    lk_valid = 1'b1; lk_kind = k; lk_vpn = v; lk_offset = off;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic hit, input logic fault,
                            input logic [19:0] ppn, input logic dirty,
                            input logic [11:0] off);
    chk(req, "rsp_valid", 64'(rsp_valid), 64'(1'b1));
    chk(req, "rsp_hit",   64'(rsp_hit),   64'(hit));
    chk(req, "rsp_miss",  64'(rsp_miss),  64'(!hit));
    chk(req, "rsp_fault", 64'(rsp_fault), 64'(fault));
    chk(req, "rsp_ppn",   64'(rsp_ppn),   64'(ppn));
    chk(req, "rsp_paddr", 64'(rsp_paddr), 64'({ppn, off}));
    chk(req, "rsp_dirty", 64'(rsp_dirty), 64'(dirty));
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_vpn = '0; lk_offset = '0; lk_kind = '0;
    rf_valid = 1'b0; rf_vpn = '0; rf_ppn = '0; rf_perm = '0; flush = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'(1'b0));
    do_lookup(2'd0, 20'h00010, 12'h055);
    expect_rsp("R1", 1'b0, 1'b0, 20'h0, 1'b0, 12'h055);

    // table setup
    do_refill(20'h00010, 20'h0A000, 3'b011);
    do_refill(20'h00020, 20'h0B000, 3'b001);
    do_refill(20'h00030, 20'h0C000, 3'b101);
    do_refill(20'hFFFFF, 20'hFFFFF, 3'b111);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < 12; i++) begin
      do_lookup(VECS[i].kind, VECS[i].vpn, VECS[i].off);
      expect_rsp(VECS[i].hit ? (VECS[i].fault ? "R4" : "R2/R5") : "R3",
                 VECS[i].hit, VECS[i].fault, VECS[i].ppn, VECS[i].dirty, VECS[i].off);
    end

    // R9 same-cycle refill and lookup
    @(negedge clk);
    rf_valid = 1'b1; rf_vpn = 20'h00050; rf_ppn = 20'h05555; rf_perm = 3'b001;
    lk_valid = 1'b1; lk_vpn = 20'h00010; lk_kind = 2'd0; lk_offset = 12'h0;
    @(negedge clk);
    rf_valid = 1'b0; lk_valid = 1'b0;
    chk("R9", "rsp_valid on collision", 64'(rsp_valid), 64'(1'b0));
    do_lookup(2'd0, 20'h00050, 12'h010);
    expect_rsp("R9", 1'b1, 1'b0, 20'h05555, 1'b0, 12'h010);

    // R8 remap in place, R5 refill clears modified flag
    do_refill(20'h00010, 20'h0ABCD, 3'b011);
    do_lookup(2'd0, 20'h00010, 12'h020);
    expect_rsp("R8", 1'b1, 1'b0, 20'h0ABCD, 1'b0, 12'h020);

    // R10 flush empties, R1 after flush
    do_flush();
    do_lookup(2'd0, 20'h00050, 12'h0);
    expect_rsp("R10", 1'b0, 1'b0, 20'h0, 1'b0, 12'h0);
    do_lookup(2'd2, 20'hFFFFF, 12'h0);
    expect_rsp("R1", 1'b0, 1'b0, 20'h0, 1'b0, 12'h0);

    // R10 flush beats refill and lookup in the same cycle
    @(negedge clk);
    flush = 1'b1; rf_valid = 1'b1; rf_vpn = 20'h00070; rf_ppn = 20'h07000; rf_perm = 3'b111;
    lk_valid = 1'b1; lk_vpn = 20'h00070; lk_kind = 2'd0;
    @(negedge clk);
    flush = 1'b0; rf_valid = 1'b0; lk_valid = 1'b0;
    chk("R10", "rsp_valid on flush cycle", 64'(rsp_valid), 64'(1'b0));
    do_lookup(2'd0, 20'h00070, 12'h0);
    expect_rsp("R10", 1'b0, 1'b0, 20'h0, 1'b0, 12'h0);

    // R6 capacity
    for (int i = 0; i < 64; i++) do_refill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 3'b111);
    for (int i = 0; i < 64; i++) begin
      do_lookup(2'd0, 20'h00100 + 20'(i), 12'(i));
      expect_rsp("R6", 1'b1, 1'b0, 20'h00200 + 20'(i), 1'b0, 12'(i));
    end

    // R7 LRU eviction
    do_lookup(2'd0, 20'h00100, 12'h0);
    expect_rsp("R7", 1'b1, 1'b0, 20'h00200, 1'b0, 12'h0);
    do_refill(20'h00500, 20'h00A00, 3'b111);
    do_lookup(2'd0, 20'h00101, 12'h0);
    expect_rsp("R7", 1'b0, 1'b0, 20'h0, 1'b0, 12'h0);
    do_lookup(2'd0, 20'h00100, 12'h0);
    expect_rsp("R7", 1'b1, 1'b0, 20'h00200, 1'b0, 12'h0);
    do_lookup(2'd0, 20'h00500, 12'h0);
    expect_rsp("R7", 1'b1, 1'b0, 20'h00A00, 1'b0, 12'h0);
    do_refill(20'h00501, 20'h00A01, 3'b111);
    do_lookup(2'd0, 20'h00102, 12'h0);
    expect_rsp("R7", 1'b0, 1'b0, 20'h0, 1'b0, 12'h0);
    do_lookup(2'd0, 20'h00501, 12'h0);
    expect_rsp("R7", 1'b1, 1'b0, 20'h00A01, 1'b0, 12'h0);

    // R8 with the buffer full: remap touches 0x00103, oldest 0x00104 survives
    do_refill(20'h00103, 20'h00777, 3'b001);
    do_lookup(2'd0, 20'h00104, 12'h0);
    expect_rsp("R8", 1'b1, 1'b0, 20'h00204, 1'b0, 12'h0);
    do_lookup(2'd1, 20'h00103, 12'h0);
    expect_rsp("R8", 1'b1, 1'b1, 20'h00777, 1'b0, 12'h0);

    // R6 R7 after flush: fill order restarts, first filled goes first
    do_flush();
    for (int i = 0; i < 64; i++) do_refill(20'h00300 + 20'(i), 20'h00400 + 20'(i), 3'b001);
    do_refill(20'h00600, 20'h00C00, 3'b001);
    do_lookup(2'd0, 20'h00300, 12'h0);
    expect_rsp("R7", 1'b0, 1'b0, 20'h0, 1'b0, 12'h0);
    do_lookup(2'd0, 20'h00301, 12'h0);
    expect_rsp("R6", 1'b1, 1'b0, 20'h00401, 1'b0, 12'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule